// File: doc/BRIEF.md
# Reset Cause and Debug Capture

This block remembers why the chip was last reset and keeps a snapshot of debug state taken at that moment. Four single-cycle request inputs report reset events: low-power entry, peripheral request, debug request and software request. A reason register collects one sticky bit per cause, and software clears those bits by writing ones.

Two capture channels sit beside the reason register. One holds processor debug data and one holds alert debug data. Each channel has a control register with an enable bit and a word index, and a lock bit that gates writes to that control register. When a qualifying reset request arrives while the enable bit is set, the channel copies its whole dump input into storage and clears the enable. Software then reads the snapshot one 32-bit word at a time by setting the index and reading the channel's info register. Once software clears a lock bit, later reset requests never set it again.

The register port is a plain write strobe with an address and write data, plus read data that follows the address in the same cycle. The bus protocol and the reset sequencing are handled elsewhere.

Top module: `rst_cause_capture`

## Requirements
- R1: Register map on the 3-bit address: 0 reason, 1 processor control, 2 processor lock, 3 processor info, 4 alert control, 5 alert lock, 6 alert info, 7 reads zero. The reason register holds bit 0 for low-power entry, bit 1 for peripheral request, bit 2 for debug request and bit 3 for software request. A request sets its bit on the next clock edge. Requests that arrive together are all recorded, and bits set earlier stay set.
- R2: A write to the reason register clears each bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. A request for a bit in the same cycle as its clear leaves that bit set.
- R3: In a control register, bit 0 is the enable and bits 6:4 are the word index. A low-power, peripheral or debug request while the processor enable is set copies the processor dump input into the processor snapshot. Word i of the snapshot is dump bits 32*i+31 down to 32*i.
- R4: A request while a channel's enable is clear leaves that channel's snapshot unchanged.
- R5: A capture clears the channel's enable bit on the same edge, so a later request does not overwrite the snapshot. The index is kept.
- R6: Any of the four requests while the alert enable is set copies the alert dump input into the alert snapshot, with the same word layout as R3.
- R7: A software request on its own neither changes the processor snapshot nor clears the processor enable, even when that enable is set.
- R8: A channel's info register reads the snapshot word selected by its index. An index at or beyond the channel's word count reads zero.
- R9: A lock bit (bit 0 of the lock register) is 1 after reset. Writing 0 to it clears it, writing 1 has no effect, and reset requests never set it again.
- R10: While a channel's lock bit is 0, writes to its control register are ignored.
- R11: After the synchronous active-low reset, the reason register, both control registers and both snapshots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_lowpwr_i | input | 1 | Low-power entry reset request pulse |
| req_periph_i | input | 1 | Peripheral reset request pulse |
| req_debug_i | input | 1 | Debug reset request pulse |
| req_sw_i | input | 1 | Software reset request pulse |
| cpu_dump_i | input | CPU_WORDS*32 | Processor debug state |
| alert_dump_i | input | ALERT_WORDS*32 | Alert debug state |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |

## Verification
Reset requests are applied one at a time, in overlapping groups, and together with clear writes. This separates a sticky bit from one that is only set for a cycle, and shows whether set or clear wins when both arrive in the same cycle. The dump inputs are changed between requests with the enable on and with it off. Comparing each word read back against the dump present at the capture edge shows whether the word order is right, whether a disabled channel stayed untouched, and whether the automatic enable clear kept the first snapshot. A software-only request with both enables set tells the two channels' trigger sets apart. A random mix of writes, lock clears and requests, checked against a bench model, shows that a cleared lock keeps blocking control writes.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
// rcc_pkg: shared constants for the reset cause and debug capture block.
// Assumes a 3-bit register address and 32-bit register words.
package rcc_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int NUM_CAUSES = 4;

    // Reason bit positions, read by software.
    localparam int CAUSE_LOWPWR = 0;
    localparam int CAUSE_PERIPH = 1;
    localparam int CAUSE_DEBUG  = 2;
    localparam int CAUSE_SW     = 3;

    // Control register fields.
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IDX_LSB = 4;

    // Lock register field.
    localparam int LOCK_BIT = 0;

    localparam logic [ADDR_W-1:0] ADDR_CAUSE      = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CPU_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CPU_LOCK   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CPU_INFO   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_ALERT_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_ALERT_LOCK = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_ALERT_INFO = 3'd6;
endpackage

// File: rtl/rcc_cause_reg.sv
`timescale 1ns/1ps
// rcc_cause_reg: sticky reset-reason bits with write-1-to-clear.
// A request in the same cycle as a clear of the same bit keeps the bit set.
// Assumes the request inputs are single-cycle pulses.
module rcc_cause_reg #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] cause_o
);
    logic [N-1:0] cause_q;
    logic [N-1:0] clr_eff;

    // Clear mask is active only on a write to this register.
    always_comb clr_eff = clr_we_i ? clr_mask_i : '0;

    // Keep old bits, drop cleared ones, then OR in new requests.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cause_q <= '0;
        else         cause_q <= (cause_q & ~clr_eff) | req_i;
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/rcc_capture_chan.sv
`timescale 1ns/1ps
// rcc_capture_chan: one debug capture channel. It holds an enable and an
// index behind a lock bit that can only be cleared. It snapshots a wide dump
// on trigger when enabled, then clears the enable. The selected word is
// presented combinationally, and an index past WORDS yields zero.
module rcc_capture_chan #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3,
    localparam int BITS  = WORDS * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic [BITS-1:0]   dump_i,
    input  logic              ctrl_we_i,
    input  logic              en_wr_i,
    input  logic [IDX_W-1:0]  idx_wr_i,
    input  logic              lock_we_i,
    input  logic              lock_wr_i,
    output logic              en_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              lock_o,
    output logic [WORD_W-1:0] word_o,
    output logic [BITS-1:0]   snap_o
);
    logic             en_q;
    logic [IDX_W-1:0] idx_q;
    logic             lock_q;
    logic [BITS-1:0]  snap_q;
    logic             capture;

    // A capture happens only when the channel is armed.
    always_comb capture = trig_i && en_q;

    // Lock starts open and can only be closed, by writing 0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                     lock_q <= 1'b1;
        else if (lock_we_i && !lock_wr_i) lock_q <= 1'b0;
    end

    // Control fields: written while unlocked; a capture disarms the enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            if (ctrl_we_i && lock_q) begin
                en_q  <= en_wr_i;
                idx_q <= idx_wr_i;
            end
            if (capture) en_q <= 1'b0;
        end
    end

    // Snapshot storage is loaded whole on a capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      snap_q <= '0;
        else if (capture) snap_q <= dump_i;
    end

    // Word select; indexes beyond WORDS match nothing and give zero.
    always_comb begin
        word_o = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (idx_q == IDX_W'(i)) word_o = snap_q[i*WORD_W +: WORD_W];
        end
    end

    assign en_o   = en_q;
    assign idx_o  = idx_q;
    assign lock_o = lock_q;
    assign snap_o = snap_q;
endmodule

// File: rtl/rst_cause_capture.sv
`timescale 1ns/1ps
// rst_cause_capture: reset reason register plus processor and alert debug
// capture channels behind a simple register port. Read data is
// combinational from the address. The processor channel triggers on
// low-power, peripheral and debug requests. The alert channel triggers on
// all four requests. Assumes request inputs are single-cycle pulses.
module rst_cause_capture
    import rcc_pkg::*;
#(
    parameter int CPU_WORDS   = 8,
    parameter int ALERT_WORDS = 8,
    parameter int IDX_W       = 3,
    localparam int CPU_BITS   = CPU_WORDS * WORD_W,
    localparam int ALERT_BITS = ALERT_WORDS * WORD_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_lowpwr_i,
    input  logic                  req_periph_i,
    input  logic                  req_debug_i,
    input  logic                  req_sw_i,
    input  logic [CPU_BITS-1:0]   cpu_dump_i,
    input  logic [ALERT_BITS-1:0] alert_dump_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [WORD_W-1:0]     reg_wdata_i,
    output logic [WORD_W-1:0]     reg_rdata_o
);
    logic [NUM_CAUSES-1:0] req_vec;
    logic [NUM_CAUSES-1:0] cause_q;
    logic                  cpu_trig, alert_trig;
    logic                  we_cause, we_cpu_ctrl, we_cpu_lock, we_alert_ctrl, we_alert_lock;
    logic                  cpu_en, alert_en, cpu_lock, alert_lock;
    logic [IDX_W-1:0]      cpu_idx, alert_idx;
    logic [WORD_W-1:0]     cpu_word, alert_word;
    logic [CPU_BITS-1:0]   cpu_snap;
    logic [ALERT_BITS-1:0] alert_snap;
    logic                  unused_wdata;

    // Gather request pulses into reason-bit order.
    always_comb begin
        req_vec               = '0;
        req_vec[CAUSE_LOWPWR] = req_lowpwr_i;
        req_vec[CAUSE_PERIPH] = req_periph_i;
        req_vec[CAUSE_DEBUG]  = req_debug_i;
        req_vec[CAUSE_SW]     = req_sw_i;
    end

    // Trigger sets: a software request leaves the processor snapshot alone.
    always_comb begin
        cpu_trig   = req_lowpwr_i | req_periph_i | req_debug_i;
        alert_trig = |req_vec;
    end

    // Register write decode.
    always_comb begin
        we_cause      = reg_we_i && (reg_addr_i == ADDR_CAUSE);
        we_cpu_ctrl   = reg_we_i && (reg_addr_i == ADDR_CPU_CTRL);
        we_cpu_lock   = reg_we_i && (reg_addr_i == ADDR_CPU_LOCK);
        we_alert_ctrl = reg_we_i && (reg_addr_i == ADDR_ALERT_CTRL);
        we_alert_lock = reg_we_i && (reg_addr_i == ADDR_ALERT_LOCK);
    end

    assign unused_wdata = ^reg_wdata_i[WORD_W-1:CTRL_IDX_LSB+IDX_W];

    rcc_cause_reg #(.N(NUM_CAUSES)) u_cause (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_vec),
        .clr_we_i   (we_cause),
        .clr_mask_i (reg_wdata_i[NUM_CAUSES-1:0]),
        .cause_o    (cause_q)
    );

    rcc_capture_chan #(.WORDS(CPU_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_cpu_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (cpu_trig),
        .dump_i    (cpu_dump_i),
        .ctrl_we_i (we_cpu_ctrl),
        .en_wr_i   (reg_wdata_i[CTRL_EN_BIT]),
        .idx_wr_i  (reg_wdata_i[CTRL_IDX_LSB +: IDX_W]),
        .lock_we_i (we_cpu_lock),
        .lock_wr_i (reg_wdata_i[LOCK_BIT]),
        .en_o      (cpu_en),
        .idx_o     (cpu_idx),
        .lock_o    (cpu_lock),
        .word_o    (cpu_word),
        .snap_o    (cpu_snap)
    );

    rcc_capture_chan #(.WORDS(ALERT_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_alert_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (alert_trig),
        .dump_i    (alert_dump_i),
        .ctrl_we_i (we_alert_ctrl),
        .en_wr_i   (reg_wdata_i[CTRL_EN_BIT]),
        .idx_wr_i  (reg_wdata_i[CTRL_IDX_LSB +: IDX_W]),
        .lock_we_i (we_alert_lock),
        .lock_wr_i (reg_wdata_i[LOCK_BIT]),
        .en_o      (alert_en),
        .idx_o     (alert_idx),
        .lock_o    (alert_lock),
        .word_o    (alert_word),
        .snap_o    (alert_snap)
    );

    // Read data multiplexer, combinational from the address.
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CAUSE:      reg_rdata_o[NUM_CAUSES-1:0] = cause_q;
            ADDR_CPU_CTRL: begin
                reg_rdata_o[CTRL_EN_BIT]                = cpu_en;
                reg_rdata_o[CTRL_IDX_LSB +: IDX_W]      = cpu_idx;
            end
            ADDR_CPU_LOCK:   reg_rdata_o[LOCK_BIT] = cpu_lock;
            ADDR_CPU_INFO:   reg_rdata_o = cpu_word;
            ADDR_ALERT_CTRL: begin
                reg_rdata_o[CTRL_EN_BIT]                = alert_en;
                reg_rdata_o[CTRL_IDX_LSB +: IDX_W]      = alert_idx;
            end
            ADDR_ALERT_LOCK: reg_rdata_o[LOCK_BIT] = alert_lock;
            ADDR_ALERT_INFO: reg_rdata_o = alert_word;
            default:         reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rcc_checker.sv
`timescale 1ns/1ps
// rcc_checker: temporal properties of rst_cause_capture, attached by bind.
// Observes ports and the state that the channel and reason submodules drive.
module rcc_checker #(
    parameter int CPU_BITS   = 256,
    parameter int ALERT_BITS = 256,
    parameter int IDX_W      = 3
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  req_lowpwr_i,
    input logic                  req_periph_i,
    input logic                  req_debug_i,
    input logic                  req_sw_i,
    input logic                  reg_we_i,
    input logic [2:0]            reg_addr_i,
    input logic [31:0]           reg_wdata_i,
    input logic [3:0]            cause_q,
    input logic                  cpu_en,
    input logic [IDX_W-1:0]      cpu_idx,
    input logic                  cpu_lock,
    input logic [CPU_BITS-1:0]   cpu_snap,
    input logic                  alert_en,
    input logic                  alert_lock,
    input logic [ALERT_BITS-1:0] alert_snap
);
    logic any_req, cpu_req;
    assign any_req = req_lowpwr_i | req_periph_i | req_debug_i | req_sw_i;
    assign cpu_req = req_lowpwr_i | req_periph_i | req_debug_i;

    assert_lowpwr_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_lowpwr_i |=> cause_q[0]);
    assert_sw_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_sw_i |=> cause_q[3]);
    assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == 3'd0 && reg_wdata_i[1] && !req_periph_i) |=> !cause_q[1]);
    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_q[2] && !(reg_we_i && reg_addr_i == 3'd0 && reg_wdata_i[2])) |=> cause_q[2]);
    assert_no_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_en |=> $stable(cpu_snap));
    assert_alert_no_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !alert_en |=> $stable(alert_snap));
    assert_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_en && cpu_req) |=> !cpu_en);
    assert_alert_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alert_en && any_req) |=> !alert_en);
    assert_sw_keeps_cpu_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_sw_i && !cpu_req) |=> $stable(cpu_snap));
    assert_lock_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_lock |=> !cpu_lock);
    assert_alert_lock_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !alert_lock |=> !alert_lock);
    assert_locked_ctrl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cpu_lock && !cpu_req) |=> ($stable(cpu_en) && $stable(cpu_idx)));
endmodule

bind rst_cause_capture rcc_checker #(
    .CPU_BITS(CPU_BITS), .ALERT_BITS(ALERT_BITS), .IDX_W(IDX_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_lowpwr_i(req_lowpwr_i), .req_periph_i(req_periph_i),
    .req_debug_i(req_debug_i), .req_sw_i(req_sw_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .cause_q(cause_q), .cpu_en(cpu_en), .cpu_idx(cpu_idx), .cpu_lock(cpu_lock),
    .cpu_snap(cpu_snap), .alert_en(alert_en), .alert_lock(alert_lock),
    .alert_snap(alert_snap)
);

// File: tb/sim_rst_cause_capture.sv
`timescale 1ns/1ps
module sim_rst_cause_capture;
    localparam int CW = 8;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rq_lp = 0, rq_pe = 0, rq_db = 0, rq_sw = 0;
    logic [CW*32-1:0] cpu_dump = '0;
    logic [AW*32-1:0] alert_dump = '0;
    logic        we = 0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench model of the register state
    logic [3:0]       m_cause = '0;
    logic             m_cen = 0, m_aen = 0, m_clock = 1, m_alock = 1;
    logic [2:0]       m_cidx = '0, m_aidx = '0;
    logic [CW*32-1:0] m_csnap = '0;
    logic [AW*32-1:0] m_asnap = '0;

    always #10 clk = ~clk;

    rst_cause_capture #(.CPU_WORDS(CW), .ALERT_WORDS(AW), .IDX_W(3)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .req_lowpwr_i(rq_lp), .req_periph_i(rq_pe), .req_debug_i(rq_db), .req_sw_i(rq_sw),
        .cpu_dump_i(cpu_dump), .alert_dump_i(alert_dump),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cpu_word(input logic [CW*32-1:0] s, input logic [2:0] i);
        return (int'(i) < CW) ? s[int'(i)*32 +: 32] : 32'h0;
    endfunction

    function automatic logic [31:0] alert_word(input logic [AW*32-1:0] s, input logic [2:0] i);
        return (int'(i) < AW) ? s[int'(i)*32 +: 32] : 32'h0;
    endfunction

    function automatic logic [31:0] ctrl_val(input logic en, input logic [2:0] idx);
        return {25'h0, idx, 3'b000, en};
    endfunction

    task automatic new_dumps();
        for (int i = 0; i < CW; i++) cpu_dump[i*32 +: 32] = $urandom;
        for (int i = 0; i < AW; i++) alert_dump[i*32 +: 32] = $urandom;
    endtask

    // One cycle of stimulus; the model advances as the design will at the next edge.
    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d, input logic [3:0] rq);
        logic ctrig, atrig, nce, nae;
        @(negedge clk);
        we = w; addr = a; wdata = d;
        {rq_sw, rq_db, rq_pe, rq_lp} = rq;
        ctrig = rq[0] | rq[1] | rq[2];
        atrig = |rq;
        if (w && a == 3'd0) m_cause = m_cause & ~d[3:0];
        m_cause = m_cause | rq;
        nce = m_cen;
        if (w && a == 3'd1 && m_clock) begin nce = d[0]; m_cidx = d[6:4]; end
        if (ctrig && m_cen) begin m_csnap = cpu_dump; nce = 1'b0; end
        nae = m_aen;
        if (w && a == 3'd4 && m_alock) begin nae = d[0]; m_aidx = d[6:4]; end
        if (atrig && m_aen) begin m_asnap = alert_dump; nae = 1'b0; end
        m_cen = nce; m_aen = nae;
        if (w && a == 3'd2 && !d[0]) m_clock = 1'b0;
        if (w && a == 3'd5 && !d[0]) m_alock = 1'b0;
        @(negedge clk);
        we = 0; {rq_sw, rq_db, rq_pe, rq_lp} = 4'h0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(3'd0, v); check({tag, " R1 reason"}, v, {28'h0, m_cause});
        rd(3'd1, v); check({tag, " R10 cpu ctrl"}, v, ctrl_val(m_cen, m_cidx));
        rd(3'd2, v); check({tag, " R9 cpu lock"}, v, {31'h0, m_clock});
        rd(3'd3, v); check({tag, " R3 cpu info"}, v, cpu_word(m_csnap, m_cidx));
        rd(3'd4, v); check({tag, " R10 alert ctrl"}, v, ctrl_val(m_aen, m_aidx));
        rd(3'd5, v); check({tag, " R9 alert lock"}, v, {31'h0, m_alock});
        rd(3'd6, v); check({tag, " R6 alert info"}, v, alert_word(m_asnap, m_aidx));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [CW*32-1:0] keep_c;
        void'($urandom(32'd2468));
        new_dumps();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check_all("R11 reset");
        rd(3'd7, v); check("R1 addr7 zero", v, 32'h0);

        // R1: single, then grouped requests
        step(0, 3'd0, 0, 4'b0001); check_all("R1 lowpwr");
        step(0, 3'd0, 0, 4'b1100); check_all("R1 grouped");
        rd(3'd0, v); check("R1 reason=D", v, 32'hD);

        // R2: write-1-to-clear, zero writes, and set winning over clear
        step(1, 3'd0, 32'h4, 4'b0000); rd(3'd0, v); check("R2 clr bit2", v, 32'h9);
        step(1, 3'd0, 32'h0, 4'b0000); rd(3'd0, v); check("R2 zero write", v, 32'h9);
        step(1, 3'd0, 32'h1, 4'b0001); rd(3'd0, v); check("R2 set wins", v, 32'h9);

        // R3, R5, R8: arm the processor channel with index 5 and capture on a peripheral request
        new_dumps();
        step(1, 3'd1, 32'h51, 4'b0000);
        step(0, 3'd0, 0, 4'b0010);
        rd(3'd1, v); check("R5 cpu disarmed", v, 32'h50);
        rd(3'd3, v); check("R3 cpu word5", v, cpu_dump[5*32 +: 32]);
        keep_c = cpu_dump;
        for (int i = 0; i < 8; i++) begin
            step(1, 3'd1, {25'h0, 3'(i), 4'h0}, 4'b0000);
            rd(3'd3, v); check("R8 cpu word", v, keep_c[i*32 +: 32]);
        end

        // R4, R5: new dump, request while disarmed
        new_dumps();
        step(0, 3'd0, 0, 4'b0100);
        rd(3'd3, v); check("R4 cpu unchanged", v, keep_c[7*32 +: 32]);

        // R7 and R6: software request with both channels armed
        step(1, 3'd1, 32'h01, 4'b0000);
        step(1, 3'd4, 32'h21, 4'b0000);
        step(0, 3'd0, 0, 4'b1000);
        rd(3'd3, v); check("R7 cpu kept", v, keep_c[0 +: 32]);
        rd(3'd1, v); check("R7 cpu still armed", v, 32'h01);
        rd(3'd6, v); check("R6 alert word2", v, alert_dump[2*32 +: 32]);
        rd(3'd4, v); check("R5 alert disarmed", v, 32'h20);
        step(1, 3'd4, 32'h60, 4'b0000);
        rd(3'd6, v); check("R8 alert idx6 zero", v, 32'h0);
        step(1, 3'd4, 32'h70, 4'b0000);
        rd(3'd6, v); check("R8 alert idx7 zero", v, 32'h0);
        check_all("directed");

        // R9, R10: lock behaviour
        step(1, 3'd2, 32'h1, 4'b0000); rd(3'd2, v); check("R9 write1 keeps", v, 32'h1);
        step(1, 3'd2, 32'h0, 4'b0000); rd(3'd2, v); check("R9 cleared", v, 32'h0);
        step(1, 3'd1, 32'h31, 4'b0000); rd(3'd1, v); check("R10 ctrl ignored", v, 32'h01);
        step(0, 3'd0, 0, 4'b1111); rd(3'd2, v); check("R9 stays clear", v, 32'h0);
        check_all("lock");

        // Random mix against the model
        for (int it = 0; it < 250; it++) begin
            logic [2:0] a;
            logic [31:0] d;
            logic [3:0] rq;
            int sel;
            sel = $urandom % 6;
            case (sel)
                0: a = 3'd0; 1: a = 3'd1; 2: a = 3'd2;
                3: a = 3'd4; 4: a = 3'd5; default: a = 3'd3;
            endcase
            d = $urandom;
            if ((a == 3'd2 || a == 3'd5) && ($urandom % 8 != 0)) d[0] = 1'b1;
            rq = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            if ($urandom % 4 == 0) new_dumps();
            step(($urandom % 4) != 0, a, d, rq);
            check_all("random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule